// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block exchanges data between one narrow port (A) and two wide-side ports (1B and 2B), all `WIDTH` bits, on one clock. Going from A toward B, it gathers two consecutive narrow words and presents them side by side on 1B and 2B. The first word passes through a two-register pipeline on the 1B side. The second word is held in a single register on the 2B side, so the two words line up. Going from B toward A, it captures both wide-side words and sends one of them to A, chosen by the select input.

Each port's output drivers are modelled as a data vector plus a drive-enable flag. A direction state machine samples the direction input on every rising edge. That state, gated by an active-low output enable, decides which side drives. As a result, bus turnaround always happens on a clock edge.

The direction state machine has two states. `DIR_B_TO_A` means A drives. `DIR_A_TO_B` means the B ports drive. On each rising edge the machine takes the state that matches the sampled direction input: 1 gives `DIR_A_TO_B` and 0 gives `DIR_B_TO_A`. Reset enters `DIR_B_TO_A`.

Top module: `nw_bus_exchanger`

## Requirements
- R1: A synchronous active-high reset clears every data register to 0 and puts the direction state in DIR_B_TO_A. After reset, a_out, b1_out and b2_out read 0, and with oe_n low a_drv is 1 while b1_drv and b2_drv are 0.
- R2: A rising edge with sel=0 loads a_in into the first 1B stage. A later rising edge with sel=1 moves that word to b1_out and loads a_in into b2_out. After that second edge, the sel=0 word and the sel=1 word appear together on b1_out and b2_out.
- R3: On consecutive sel=1 edges, b2_out reloads a_in on every edge, while b1_out keeps the word last loaded with sel=0.
- R4: A rising edge with sel=0 leaves b1_out and b2_out unchanged.
- R5: b1_in, b2_in and sel are sampled together on a rising edge. After the following edge, a_out shows b1_in if that sampled sel was 0, and b2_in if it was 1.
- R6: While oe_n is 1, a_drv, b1_drv and b2_drv are all 0, with no clock edge needed.
- R7: While oe_n is 0, direction state DIR_A_TO_B (sampled dir=1) sets b1_drv and b2_drv to 1 and a_drv to 0. State DIR_B_TO_A (sampled dir=0) does the opposite. A change on dir changes the enables only after the next rising edge.
- R8: a_drv and the B-side drive flags are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers capture on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Word select for gathering (A to B) and for choosing a half (B to A) |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | Direction request, sampled each edge (1 = B ports drive) |
| a_in | input | WIDTH | Narrow port receive data |
| a_out | output | WIDTH | Narrow port transmit data |
| a_drv | output | 1 | Narrow port drive enable |
| b1_in | input | WIDTH | First wide-side receive data |
| b1_out | output | WIDTH | First wide-side transmit data |
| b1_drv | output | 1 | First wide-side drive enable |
| b2_in | input | WIDTH | Second wide-side receive data |
| b2_out | output | WIDTH | Second wide-side transmit data |
| b2_drv | output | 1 | Second wide-side drive enable |

## Verification
Two functions can fall on the same clock edge: a bus turnaround and the sel=1 edge that completes a gathered pair. The bench provokes this by raising dir on the very edge that takes the second word. It then judges that, after that single edge, the B drive flags are set and both halves of the pair are already present on b1_out and b2_out. Before the edge, the bench confirms that the enables have not yet moved.

// File: rtl/nwx_pkg.sv
package nwx_pkg;
    typedef enum logic {
        DIR_B_TO_A = 1'b0,
        DIR_A_TO_B = 1'b1
    } xdir_e;
endpackage

// File: rtl/nwx_dir_fsm.sv
module nwx_dir_fsm
    import nwx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dir,
    input  logic oe_n,
    output logic a_en,
    output logic b_en
);
    xdir_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            DIR_B_TO_A: state_d = dir ? DIR_A_TO_B : DIR_B_TO_A;
            DIR_A_TO_B: state_d = dir ? DIR_A_TO_B : DIR_B_TO_A;
            default:    state_d = DIR_B_TO_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DIR_B_TO_A;
        else     state_q <= state_d;
    end

    always_comb begin
        a_en = 1'b0;
        b_en = 1'b0;
        unique case (state_q)
            DIR_B_TO_A: a_en = !oe_n;
            DIR_A_TO_B: b_en = !oe_n;
            default: ;
        endcase
    end

    // R7: the enables follow the direction sampled on the previous edge
    a_r7_dir_registered: assert property (@(posedge clk) disable iff (rst)
        !oe_n |=> oe_n || (b_en == $past(dir)));
    // R8: never both sides driving
    a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
        !(a_en && b_en));
    // R6: output enable high silences every driver
    always_comb begin
        if (!rst && oe_n)
            a_r6_oe_off: assert (!a_en && !b_en);
    end
endmodule

// File: rtl/nwx_a2b_path.sv
module nwx_a2b_path #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] b1_out,
    output logic [WIDTH-1:0] b2_out
);
    logic [WIDTH-1:0] first_q, second_q, wide2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q  <= '0;
            second_q <= '0;
            wide2_q  <= '0;
        end else if (sel) begin
            second_q <= first_q;
            wide2_q  <= a_in;
        end else begin
            first_q  <= a_in;
        end
    end

    assign b1_out = second_q;
    assign b2_out = wide2_q;

    // R4: a select-low edge leaves the wide side untouched
    a_r4_low_holds: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(b1_out) && $stable(b2_out));
    // R3: a select-high edge reloads the second wide word from the narrow port
    a_r3_high_loads: assert property (@(posedge clk) disable iff (rst)
        sel |=> b2_out == $past(a_in));
    // R2: a low edge followed by a high edge delivers the low word on 1B
    a_r2_pair_aligned: assert property (@(posedge clk) disable iff (rst)
        (!$past(sel) && sel) |=> b1_out == $past(a_in, 2));
endmodule

// File: rtl/nwx_b2a_path.sv
module nwx_b2a_path #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic [WIDTH-1:0] b1_in,
    input  logic [WIDTH-1:0] b2_in,
    output logic [WIDTH-1:0] a_out
);
    logic [WIDTH-1:0] cap1_q, cap2_q, narrow_q;
    logic             pick_q;
    logic [1:0]       age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap1_q   <= '0;
            cap2_q   <= '0;
            pick_q   <= 1'b0;
            narrow_q <= '0;
        end else begin
            cap1_q   <= b1_in;
            cap2_q   <= b2_in;
            pick_q   <= sel;
            narrow_q <= pick_q ? cap2_q : cap1_q;
        end
    end

    assign a_out = narrow_q;

    // cycles since reset, saturating, so the two-edge check never reaches before reset
    always_ff @(posedge clk) begin
        if (rst)               age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R5: the half chosen two edges ago by sel appears on A
    a_r5_select_latency: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |->
            a_out == ($past(sel, 2) ? $past(b2_in, 2) : $past(b1_in, 2)));
endmodule

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             oe_n,
    input  logic             dir,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drv,
    input  logic [WIDTH-1:0] b1_in,
    output logic [WIDTH-1:0] b1_out,
    output logic             b1_drv,
    input  logic [WIDTH-1:0] b2_in,
    output logic [WIDTH-1:0] b2_out,
    output logic             b2_drv
);
    logic b_en;

    nwx_dir_fsm u_dir (
        .clk  (clk),
        .rst  (rst),
        .dir  (dir),
        .oe_n (oe_n),
        .a_en (a_drv),
        .b_en (b_en)
    );

    nwx_a2b_path #(.WIDTH(WIDTH)) u_a2b (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .a_in   (a_in),
        .b1_out (b1_out),
        .b2_out (b2_out)
    );

    nwx_b2a_path #(.WIDTH(WIDTH)) u_b2a (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .b1_in (b1_in),
        .b2_in (b2_in),
        .a_out (a_out)
    );

    assign b1_drv = b_en;
    assign b2_drv = b_en;

    // R1: the cycle after reset, all data outputs are cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (a_out == '0) && (b1_out == '0) && (b2_out == '0));
endmodule

// File: tb/tb_nw_bus_exchanger.sv
module tb_nw_bus_exchanger;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst, sel, oe_n, dir;
    logic [W-1:0] a_in, b1_in, b2_in;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_drv, b1_drv, b2_drv;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nw_bus_exchanger #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .sel(sel), .oe_n(oe_n), .dir(dir),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b1_in(b1_in), .b1_out(b1_out), .b1_drv(b1_drv),
        .b2_in(b2_in), .b2_out(b2_out), .b2_drv(b2_drv)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; sel = 1'b0; oe_n = 1'b0; dir = 1'b0;
        a_in = '1; b1_in = '1; b2_in = '1;
        tick(); tick();
        rst = 1'b0;
        chk("R1 a_out", a_out, '0);
        chk("R1 b1_out", b1_out, '0);
        chk("R1 b2_out", b2_out, '0);
        chk("R1 a_drv", W'(a_drv), W'(1));
        chk("R1 b_drv", W'({b1_drv, b2_drv}), W'(0));
    endtask

    task automatic t_oe_off();
        oe_n = 1'b1;
        #1;
        chk("R6 drives off", W'({a_drv, b1_drv, b2_drv}), W'(0));
        dir = 1'b1; tick();
        chk("R6 drives off after dir", W'({a_drv, b1_drv, b2_drv}), W'(0));
        dir = 1'b0; tick();
        oe_n = 1'b0;
        #1;
        chk("R6 drive back", W'(a_drv), W'(1));
    endtask

    // turnaround and pair completion on the same edge
    task automatic t_turnaround_pair();
        sel = 1'b0; a_in = 18'h1A2B3; tick();
        chk("R4 b1 hold", b1_out, '0);
        chk("R4 b2 hold", b2_out, '0);
        sel = 1'b1; a_in = 18'h0C0DE; dir = 1'b1;
        #1;
        chk("R7 not yet", W'({a_drv, b1_drv}), W'(2'b10));
        tick();
        chk("R7 b drives", W'({a_drv, b1_drv, b2_drv}), W'(3'b011));
        chk("R2 b1 pair", b1_out, 18'h1A2B3);
        chk("R2 b2 pair", b2_out, 18'h0C0DE);
        chk("R8 exclusive", W'(a_drv & b1_drv), W'(0));
    endtask

    task automatic t_stream();
        for (int i = 0; i < 4; i++) begin
            logic [W-1:0] lo, hi, b1p, b2p;
            lo = W'(18'h00111 * (i + 1));
            hi = W'(18'h3FFFF - 18'h00222 * i);
            b1p = b1_out; b2p = b2_out;
            sel = 1'b0; a_in = lo; tick();
            chk("R4 b1 stable", b1_out, b1p);
            chk("R4 b2 stable", b2_out, b2p);
            sel = 1'b1; a_in = hi; tick();
            chk("R2 b1 low word", b1_out, lo);
            chk("R2 b2 high word", b2_out, hi);
        end
    endtask

    task automatic t_repeat_high();
        logic [W-1:0] keep;
        keep = b1_out;
        for (int i = 0; i < 3; i++) begin
            sel = 1'b1; a_in = W'(18'h2A000 + i); tick();
            chk("R3 b2 reload", b2_out, W'(18'h2A000 + i));
            chk("R3 b1 kept", b1_out, keep);
        end
    endtask

    task automatic t_b_to_a();
        dir = 1'b0; tick();
        chk("R7 a drives", W'({a_drv, b1_drv, b2_drv}), W'(3'b100));
        b1_in = 18'h11111; b2_in = 18'h22222; sel = 1'b0; tick();
        b1_in = 18'h33333; b2_in = 18'h04444; sel = 1'b1; tick();
        chk("R5 sel0 picks 1B", a_out, 18'h11111);
        b1_in = 18'h05555; b2_in = 18'h06666; sel = 1'b0; tick();
        chk("R5 sel1 picks 2B", a_out, 18'h04444);
        b1_in = '0; b2_in = '0; tick();
        chk("R5 sel0 again", a_out, 18'h05555);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_oe_off();
        t_turnaround_pair();
        t_stream();
        t_repeat_high();
        t_b_to_a();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule